// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block runs the one-time start-up command sequence that a DDR3 device needs before normal traffic may begin. It works entirely in the controller clock domain. Once reset is released it raises the clock-enable pin, waits, then loads the four mode registers one after another with values fixed at build time. It ends with a long ZQ calibration command. Every gap between two steps is a build-time parameter counted in controller cycles. The gap is chosen from the pair formed by the step just issued and the step that comes next.

The outputs are the command pins, the bank and address buses and the clock-enable pin, plus a completion flag. A main scheduler watches the completion flag and takes over the command bus once it goes high. In every cycle that carries no command, the sequencer drives a no-operation code with chip select active.

Top module: `ddr3_init_seq`

## Requirements
- R1: While reset is asserted, ddr_cke is 0, init_done is 0, the pins carry no-operation (cs_n=0, ras_n=1, cas_n=1, we_n=1), and ddr_ba and ddr_addr are 0.
- R2: After reset is released, ddr_cke rises once and then stays 1 until the next reset.
- R3: The first mode-register command appears exactly T_XPR cycles after the first cycle in which ddr_cke is 1.
- R4: Exactly four mode-register commands are issued, each coded as cs_n, ras_n, cas_n and we_n all 0. Their bank values are 2, 3, 1 and 0 in that order, and each carries MR2_VAL, MR3_VAL, MR1_VAL and MR0_VAL on ddr_addr respectively.
- R5: Consecutive mode-register commands are exactly T_MRD cycles apart.
- R6: One ZQ calibration command follows the last mode-register command by exactly T_MOD cycles. It is coded as cs_n=0, ras_n=1, cas_n=1, we_n=0, with ddr_addr bit 10 set, every other address bit 0, and ddr_ba 0.
- R7: init_done rises exactly T_ZQINIT cycles after the ZQ calibration command and stays 1 until reset. No further command is issued after the ZQ calibration command.
- R8: In every cycle that carries no command, the pins hold no-operation. The only codes that ever appear are no-operation, mode-register set and ZQ calibration.
- R9: A reset asserted in the middle of the sequence returns the outputs to the R1 state at once. After release, the complete sequence runs again from the clock-enable step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ddr_cke | output | 1 | Clock enable to the memory device |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe command pin, active low |
| ddr_cas_n | output | 1 | Column strobe command pin, active low |
| ddr_we_n | output | 1 | Write-enable command pin, active low |
| ddr_ba | output | 3 | Bank address; selects the mode register during a mode-register command |
| ddr_addr | output | ADDR_W | Address bus; carries the register setting, or bit 10 set for ZQ calibration |
| init_done | output | 1 | High once initialization is complete; hands the bus to the scheduler |

## Verification
The assertions check several properties on every cycle. They check that only the three legal command codes ever appear and that clock enable and the completion flag never fall outside reset. They check that nothing is issued once the completion flag is high and that every ZQ command carries the correct address. They also measure each gap (clock enable to first mode-register command, between mode-register commands, to calibration, and to completion) with a cycle counter and compare it against the parameter for that pair of steps. Only the bench scenarios can show the order of the four mode-register targets and the exact settings they carry, that exactly five commands are issued and no more, and that a reset in mid-sequence restarts the whole sequence.

// File: rtl/ddr3i_pkg.sv
package ddr3i_pkg;

  typedef enum logic [2:0] {
    ST_CKE  = 3'd0,
    ST_WAIT = 3'd1,
    ST_CMD  = 3'd2,
    ST_DONE = 3'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_MRS  = 2'd1,
    CMD_ZQCL = 2'd2
  } cmd_kind_e;

  localparam int unsigned N_MRS = 4;

  // {cs_n, ras_n, cas_n, we_n}
  function automatic logic [3:0] cmd_pins(cmd_kind_e k);
    case (k)
      CMD_MRS:  cmd_pins = 4'b0000;
      CMD_ZQCL: cmd_pins = 4'b0110;
      default:  cmd_pins = 4'b0111;
    endcase
  endfunction

endpackage

// File: rtl/ddr3i_rst_sync.sv
module ddr3i_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ddr3i_wait_ctr.sv
module ddr3i_wait_ctr #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign zero = (cnt_q == '0);

  always_comb begin
    cnt_en = load | (dec & ~zero);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ddr3i_step_fsm.sv
module ddr3i_step_fsm
  import ddr3i_pkg::*;
#(
  parameter int unsigned T_XPR    = 60,
  parameter int unsigned T_MRD    = 4,
  parameter int unsigned T_MOD    = 12,
  parameter int unsigned T_ZQINIT = 512,
  parameter int unsigned CNT_W    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_zero,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_load_val,
  output logic             cnt_dec,
  output cmd_kind_e        cmd_kind,
  output logic [1:0]       mr_idx,
  output logic             cke_set,
  output logic             seq_done
);
  localparam int unsigned STEP_W = $clog2(N_MRS + 2);
  localparam logic [STEP_W-1:0] STEP_LAST_MRS = STEP_W'(N_MRS - 1);
  localparam logic [STEP_W-1:0] STEP_ZQ       = STEP_W'(N_MRS);
  // A wait of W cycles between two issue cycles loads W-2:
  // one cycle is the issue cycle itself, one is the cycle the counter reads zero.
  localparam logic [CNT_W-1:0] LD_XPR    = CNT_W'(T_XPR - 2);
  localparam logic [CNT_W-1:0] LD_MRD    = CNT_W'(T_MRD - 2);
  localparam logic [CNT_W-1:0] LD_MOD    = CNT_W'(T_MOD - 2);
  localparam logic [CNT_W-1:0] LD_ZQINIT = CNT_W'(T_ZQINIT - 2);

  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              step_en;

  always_comb begin
    state_d      = state_q;
    step_d       = step_q + 1'b1;
    step_en      = 1'b0;
    cnt_load     = 1'b0;
    cnt_load_val = LD_XPR;
    cmd_kind     = CMD_NOP;
    cke_set      = 1'b0;
    seq_done     = 1'b0;
    case (state_q)
      ST_CKE: begin
        cke_set  = 1'b1;
        cnt_load = 1'b1;
        state_d  = ST_WAIT;
      end
      ST_WAIT: begin
        if (cnt_zero) state_d = (step_q > STEP_ZQ) ? ST_DONE : ST_CMD;
      end
      ST_CMD: begin
        cnt_load = 1'b1;
        step_en  = 1'b1;
        state_d  = ST_WAIT;
        if (step_q == STEP_ZQ) begin
          cmd_kind     = CMD_ZQCL;
          cnt_load_val = LD_ZQINIT;
        end else begin
          cmd_kind     = CMD_MRS;
          cnt_load_val = (step_q == STEP_LAST_MRS) ? LD_MOD : LD_MRD;
        end
      end
      default: begin
        seq_done = 1'b1;
      end
    endcase
  end

  assign cnt_dec = (state_q == ST_WAIT);
  assign mr_idx  = step_q[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_CKE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       step_q <= '0;
    else if (step_en) step_q <= step_d;
  end
endmodule

// File: rtl/ddr3i_cmd_drv.sv
module ddr3i_cmd_drv
  import ddr3i_pkg::*;
#(
  parameter int unsigned ADDR_W = 14,
  parameter logic [13:0] MR0_VAL = 14'h1D70,
  parameter logic [13:0] MR1_VAL = 14'h0044,
  parameter logic [13:0] MR2_VAL = 14'h0008,
  parameter logic [13:0] MR3_VAL = 14'h0002
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_kind_e         cmd_kind,
  input  logic [1:0]        mr_idx,
  input  logic              cke_set,
  input  logic              seq_done,
  output logic              ddr_cke,
  output logic              ddr_cs_n,
  output logic              ddr_ras_n,
  output logic              ddr_cas_n,
  output logic              ddr_we_n,
  output logic [2:0]        ddr_ba,
  output logic [ADDR_W-1:0] ddr_addr,
  output logic              init_done
);
  localparam logic [ADDR_W-1:0] ZQ_ADDR = ADDR_W'(1) << 10;

  logic [3:0]        pins_d, pins_q;
  logic [2:0]        ba_d, ba_q;
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic              cke_q, done_q;
  logic              pins_en;
  logic [1:0]        mr_sel;
  logic [13:0]       mr_val;

  // Issue order of the mode registers: 2, 3, 1, 0
  always_comb begin
    case (mr_idx)
      2'd0:    mr_sel = 2'd2;
      2'd1:    mr_sel = 2'd3;
      2'd2:    mr_sel = 2'd1;
      default: mr_sel = 2'd0;
    endcase
    case (mr_sel)
      2'd0:    mr_val = MR0_VAL;
      2'd1:    mr_val = MR1_VAL;
      2'd2:    mr_val = MR2_VAL;
      default: mr_val = MR3_VAL;
    endcase
  end

  always_comb begin
    pins_en = 1'b1;
    pins_d  = cmd_pins(cmd_kind);
    ba_d    = '0;
    addr_d  = '0;
    if (cmd_kind == CMD_MRS) begin
      ba_d   = {1'b0, mr_sel};
      addr_d = ADDR_W'(mr_val);
    end else if (cmd_kind == CMD_ZQCL) begin
      addr_d = ZQ_ADDR;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q <= 4'b0111;
      ba_q   <= '0;
      addr_q <= '0;
    end else if (pins_en) begin
      pins_q <= pins_d;
      ba_q   <= ba_d;
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cke_q <= 1'b0;
    else if (cke_set) cke_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        done_q <= 1'b0;
    else if (seq_done) done_q <= 1'b1;
  end

  assign {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} = pins_q;
  assign ddr_ba    = ba_q;
  assign ddr_addr  = addr_q;
  assign ddr_cke   = cke_q;
  assign init_done = done_q;
endmodule

// File: rtl/ddr3_init_seq.sv
module ddr3_init_seq
  import ddr3i_pkg::*;
#(
  parameter int unsigned ADDR_W   = 14,
  parameter int unsigned T_XPR    = 60,
  parameter int unsigned T_MRD    = 4,
  parameter int unsigned T_MOD    = 12,
  parameter int unsigned T_ZQINIT = 512,
  parameter logic [13:0] MR0_VAL  = 14'h1D70,
  parameter logic [13:0] MR1_VAL  = 14'h0044,
  parameter logic [13:0] MR2_VAL  = 14'h0008,
  parameter logic [13:0] MR3_VAL  = 14'h0002
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              ddr_cke,
  output logic              ddr_cs_n,
  output logic              ddr_ras_n,
  output logic              ddr_cas_n,
  output logic              ddr_we_n,
  output logic [2:0]        ddr_ba,
  output logic [ADDR_W-1:0] ddr_addr,
  output logic              init_done
);
  localparam int unsigned MAX_A = (T_XPR > T_MOD) ? T_XPR : T_MOD;
  localparam int unsigned MAX_B = (T_ZQINIT > T_MRD) ? T_ZQINIT : T_MRD;
  localparam int unsigned MAX_W = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CNT_W = $clog2(MAX_W + 1);

  logic             rst_sync_n;
  logic             cnt_load, cnt_dec, cnt_zero;
  logic [CNT_W-1:0] cnt_load_val;
  cmd_kind_e        cmd_kind;
  logic [1:0]       mr_idx;
  logic             cke_set, seq_done;

  ddr3i_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ddr3i_wait_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (cnt_load),
    .load_val (cnt_load_val),
    .dec      (cnt_dec),
    .zero     (cnt_zero)
  );

  ddr3i_step_fsm #(
    .T_XPR(T_XPR), .T_MRD(T_MRD), .T_MOD(T_MOD), .T_ZQINIT(T_ZQINIT), .CNT_W(CNT_W)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .cnt_zero     (cnt_zero),
    .cnt_load     (cnt_load),
    .cnt_load_val (cnt_load_val),
    .cnt_dec      (cnt_dec),
    .cmd_kind     (cmd_kind),
    .mr_idx       (mr_idx),
    .cke_set      (cke_set),
    .seq_done     (seq_done)
  );

  ddr3i_cmd_drv #(
    .ADDR_W(ADDR_W), .MR0_VAL(MR0_VAL), .MR1_VAL(MR1_VAL),
    .MR2_VAL(MR2_VAL), .MR3_VAL(MR3_VAL)
  ) u_drv (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cmd_kind  (cmd_kind),
    .mr_idx    (mr_idx),
    .cke_set   (cke_set),
    .seq_done  (seq_done),
    .ddr_cke   (ddr_cke),
    .ddr_cs_n  (ddr_cs_n),
    .ddr_ras_n (ddr_ras_n),
    .ddr_cas_n (ddr_cas_n),
    .ddr_we_n  (ddr_we_n),
    .ddr_ba    (ddr_ba),
    .ddr_addr  (ddr_addr),
    .init_done (init_done)
  );
endmodule

// File: rtl/ddr3_init_seq_chk.sv
module ddr3_init_seq_chk #(
  parameter int unsigned ADDR_W   = 14,
  parameter int unsigned T_XPR    = 60,
  parameter int unsigned T_MRD    = 4,
  parameter int unsigned T_MOD    = 12,
  parameter int unsigned T_ZQINIT = 512
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ddr_cke,
  input logic              ddr_cs_n,
  input logic              ddr_ras_n,
  input logic              ddr_cas_n,
  input logic              ddr_we_n,
  input logic [2:0]        ddr_ba,
  input logic [ADDR_W-1:0] ddr_addr,
  input logic              init_done
);
  typedef enum logic [1:0] {EV_NONE, EV_CKE, EV_MRS, EV_ZQ} ev_e;

  logic [3:0]  pins;
  logic        is_nop, is_mrs, is_zq, cke_rise, done_rise, any_ev;
  logic        cke_prev, done_prev;
  logic [15:0] gap_q;
  ev_e         last_q;

  assign pins      = {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n};
  assign is_nop    = (pins == 4'b0111);
  assign is_mrs    = (pins == 4'b0000);
  assign is_zq     = (pins == 4'b0110);
  assign cke_rise  = ddr_cke & ~cke_prev;
  assign done_rise = init_done & ~done_prev;
  assign any_ev    = cke_rise | is_mrs | is_zq | done_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_prev  <= 1'b0;
      done_prev <= 1'b0;
      gap_q     <= 16'd1;
      last_q    <= EV_NONE;
    end else begin
      cke_prev  <= ddr_cke;
      done_prev <= init_done;
      if (any_ev) gap_q <= 16'd1;
      else if (gap_q != 16'hFFFF) gap_q <= gap_q + 16'd1;
      if (cke_rise)    last_q <= EV_CKE;
      else if (is_mrs) last_q <= EV_MRS;
      else if (is_zq)  last_q <= EV_ZQ;
    end
  end

  assert_legal_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_nop || is_mrs || is_zq));

  assert_cke_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ddr_cke |=> ddr_cke);

  assert_mrs_needs_cke_R4: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |-> ddr_cke);

  assert_xpr_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mrs && last_q == EV_CKE) |-> (gap_q == 16'(T_XPR)));

  assert_mrd_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mrs && last_q == EV_MRS) |-> (gap_q == 16'(T_MRD)));

  assert_mod_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    is_zq |-> (last_q == EV_MRS && gap_q == 16'(T_MOD)));

  assert_zq_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    is_zq |-> (ddr_addr == (ADDR_W'(1) << 10) && ddr_ba == 3'd0));

  assert_zqinit_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_rise |-> (last_q == EV_ZQ && gap_q == 16'(T_ZQINIT)));

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  assert_quiet_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> is_nop);
endmodule

bind ddr3_init_seq ddr3_init_seq_chk #(
  .ADDR_W(ADDR_W), .T_XPR(T_XPR), .T_MRD(T_MRD), .T_MOD(T_MOD), .T_ZQINIT(T_ZQINIT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ddr_cke   (ddr_cke),
  .ddr_cs_n  (ddr_cs_n),
  .ddr_ras_n (ddr_ras_n),
  .ddr_cas_n (ddr_cas_n),
  .ddr_we_n  (ddr_we_n),
  .ddr_ba    (ddr_ba),
  .ddr_addr  (ddr_addr),
  .init_done (init_done)
);

// File: tb/tb_ddr3_init_seq.sv
`timescale 1ns/1ps
module tb_ddr3_init_seq;
  localparam int unsigned ADDR_W = 14;
  localparam int unsigned P_XPR = 24, P_MRD = 4, P_MOD = 12, P_ZQ = 300;
  localparam logic [13:0] V0 = 14'h1D70, V1 = 14'h0044, V2 = 14'h0008, V3 = 14'h0002;

  typedef enum int {E_CKE, E_MRS, E_ZQ, E_DONE} ev_e;
  typedef struct {
    ev_e         kind;
    logic [2:0]  ba;
    logic [13:0] addr;
    int          gap;
    string       req;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic ddr_cke, ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n, init_done;
  logic [2:0] ddr_ba;
  logic [ADDR_W-1:0] ddr_addr;

  int tests = 0, fails = 0, n_events = 0, cyc = 0, last_cyc = 0;
  bit finished = 0;
  bit p_cke = 0, p_done = 0;
  item_t q[$];

  always #4 clk = ~clk;

  ddr3_init_seq #(
    .ADDR_W(ADDR_W), .T_XPR(P_XPR), .T_MRD(P_MRD), .T_MOD(P_MOD), .T_ZQINIT(P_ZQ),
    .MR0_VAL(V0), .MR1_VAL(V1), .MR2_VAL(V2), .MR3_VAL(V3)
  ) dut (
    .clk(clk), .rst_n(rst_n), .ddr_cke(ddr_cke), .ddr_cs_n(ddr_cs_n),
    .ddr_ras_n(ddr_ras_n), .ddr_cas_n(ddr_cas_n), .ddr_we_n(ddr_we_n),
    .ddr_ba(ddr_ba), .ddr_addr(ddr_addr), .init_done(init_done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input ev_e k, input logic [2:0] b, input logic [13:0] a,
                      input int g, input string r);
    item_t it;
    it.kind = k; it.ba = b; it.addr = a; it.gap = g; it.req = r;
    q.push_back(it);
  endtask

  task automatic push_sequence();
    push(E_CKE,  3'd0, 14'h0,   0,     "R2");
    push(E_MRS,  3'd2, V2,      P_XPR, "R3");
    push(E_MRS,  3'd3, V3,      P_MRD, "R4");
    push(E_MRS,  3'd1, V1,      P_MRD, "R5");
    push(E_MRS,  3'd0, V0,      P_MRD, "R4");
    push(E_ZQ,   3'd0, 14'h400, P_MOD, "R6");
    push(E_DONE, 3'd0, 14'h0,   P_ZQ,  "R7");
  endtask

  task automatic handle(input ev_e k, input logic [2:0] b, input logic [13:0] a);
    item_t e;
    if (q.size() == 0) begin
      check(1'b0, "R8", "unexpected event", int'(k), -1);
    end else begin
      e = q.pop_front();
      check(k == e.kind, e.req, "event kind", int'(k), int'(e.kind));
      if (k == E_MRS || k == E_ZQ) begin
        check(b == e.ba, e.req, "bank", int'(b), int'(e.ba));
        check(a == e.addr, e.req, "address", int'(a), int'(e.addr));
      end
      if (e.gap != 0)
        check((cyc - last_cyc) == e.gap, e.req, "gap cycles", cyc - last_cyc, e.gap);
    end
    last_cyc = cyc;
    n_events++;
  endtask

  // Monitor: sample away from the active edge
  always @(negedge clk) begin
    logic [3:0] pins;
    cyc++;
    pins = {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n};
    if (!rst_n) begin
      p_cke = 0; p_done = 0;
    end else begin
      if (!(pins == 4'b0111 || pins == 4'b0000 || pins == 4'b0110))
        check(1'b0, "R8", "illegal command code", int'(pins), 7);
      if (p_cke && !ddr_cke) check(1'b0, "R2", "cke fell", 0, 1);
      if (p_done && !init_done) check(1'b0, "R7", "init_done fell", 0, 1);
      if (init_done && pins != 4'b0111) check(1'b0, "R7", "command after done", int'(pins), 7);
      if (ddr_cke && !p_cke) handle(E_CKE, 3'd0, 14'h0);
      if (pins == 4'b0000) handle(E_MRS, ddr_ba, ddr_addr);
      if (pins == 4'b0110) handle(E_ZQ, ddr_ba, ddr_addr);
      if (init_done && !p_done) handle(E_DONE, 3'd0, 14'h0);
      p_cke = ddr_cke; p_done = init_done;
    end
  end

  task automatic check_reset_state(input string req);
    check(ddr_cke == 1'b0, req, "cke in reset", int'(ddr_cke), 0);
    check(init_done == 1'b0, req, "init_done in reset", int'(init_done), 0);
    check({ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} == 4'b0111, req, "pins in reset",
          int'({ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n}), 7);
    check(ddr_ba == 3'd0 && ddr_addr == '0, req, "bus in reset",
          int'({ddr_ba, ddr_addr}), 0);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired: actual=0 expected=1");
      finish_run();
    end
  end

  initial begin
    #2 rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check_reset_state("R1");

    // Full sequence
    push_sequence();
    rst_n = 1'b1;
    while (!init_done) @(negedge clk);
    repeat (60) @(negedge clk);
    check(q.size() == 0, "R7", "items left", q.size(), 0);
    check(n_events == 7, "R8", "event count", n_events, 7);

    // Reset in mid-sequence
    n_events = 0;
    push_sequence();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    while (n_events < 3) @(negedge clk);
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_reset_state("R9");
    @(negedge clk);
    check_reset_state("R9");
    q.delete();
    n_events = 0;
    push_sequence();
    rst_n = 1'b1;
    while (!init_done) @(negedge clk);
    repeat (40) @(negedge clk);
    check(q.size() == 0, "R9", "items left after restart", q.size(), 0);
    check(n_events == 7, "R9", "events after restart", n_events, 7);
    finish_run();
  end
endmodule